// File: doc/BRIEF.md
# Output-Side Input Preference Ranker

This block serves one output port of an N-by-N crossbar switch that keeps queues both at its inputs and at its outputs. At each scheduling phase it produces a ranked list of input ports, which the output hands to the input/output matcher as its preference list. An input appears in the list only when it still holds at least one cell for this output. The list order is the order in which the head cell of each listed input would leave the output link. That order assumes the link policy is replayed on the cells already waiting at the output, with no new arrivals.

Two link policies are supported. In round-robin mode, an input with fewer cells already waiting at the output ranks earlier. Equal counts are ordered by ring distance from a round-robin pointer. In static-priority mode, a per-input configured level decides the order. At each departure phase the block also names the per-input output queue that sends next. In round-robin mode it then moves the pointer just past that input. Cell storage and the matcher live elsewhere. Queue state enters as flat vectors and the bench or fabric applies the departures.

Top module: `port_pref_gen`

## Requirements
- R1: While and after reset, `pref_vld` is all zero, `list_fresh` and `dep_valid` are low, and the round-robin pointer is at input 0.
- R2: A list holds exactly the inputs whose `voq_busy` bit is set. Valid slots form a prefix from slot 0, and slots without a valid entry read index 0. Inputs with output-side cells but a clear `voq_busy` bit never appear.
- R3: With `pol_rr`=1, listed inputs are ordered by increasing `viq_count` field, where field i sits at bits [i*CW +: CW].
- R4: With `pol_rr`=1, inputs with equal counts are ordered by ring distance (i - pointer) mod N, the smallest first.
- R5: With `pol_rr`=0, listed inputs are ordered by increasing `prio_lvl` field (field i at bits [i*IW +: IW], a lower value is preferred), equal levels by lower index. Counts have no effect.
- R6: Slot k (bits [k*IW +: IW]) holds the input of rank k+1, and no input occupies two valid slots.
- R7: The list is loaded at the clock edge that samples `sched_go` high, and `list_fresh` is high for the following cycle. Otherwise the list holds its value.
- R8: At an edge sampling `depart_go`, with `pol_rr`=1, the chosen queue is the first input with a non-zero count going around the ring from the pointer. `dep_valid` and `dep_idx` show it in the following cycle. When every count is zero, `dep_valid` stays low.
- R9: With `pol_rr`=0, a departure chooses the non-empty queue with the lowest level, with ties going to the lower index.
- R10: A round-robin departure from input i sets the pointer to (i+1) mod N. A static-priority departure, or one with nothing to send, leaves the pointer unchanged.
- R11: When `sched_go` and `depart_go` are sampled high together, the departure is performed and the scheduling request is ignored. The list is unchanged and `list_fresh` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_rr | input | 1 | 1 = round-robin policy, 0 = static priority |
| sched_go | input | 1 | Start of a scheduling phase |
| depart_go | input | 1 | Start of a departure phase |
| voq_busy | input | N | Bit i: input i holds a cell for this output |
| viq_count | input | N*CW | Per-input occupancy of the output-side queues |
| prio_lvl | input | N*IW | Per-input static priority level |
| pref_idx | output | N*IW | Ranked input indices, slot 0 first |
| pref_vld | output | N | Per-slot valid bits |
| list_fresh | output | 1 | List was loaded at the last edge |
| dep_valid | output | 1 | A cell departs from queue `dep_idx` |
| dep_idx | output | IW | Input whose output-side queue sends |

## Verification
The bench concentrates on inputs that are eligible but have nothing waiting at the output, on ineligible inputs that do have waiting cells, and on occupancy ties seen from several pointer positions. A ranker that lists ineligible inputs, or that breaks ties by plain index, would produce a wrong slot order. Pointer wrap from the last input to input 0, and static-mode departures, are followed by round-robin tie lists that expose the pointer. A design that advanced the pointer on every departure, or failed to wrap, would reorder those lists. Simultaneous phase strobes and all-empty departures confirm that a design which reloaded the list or raised `dep_valid` spuriously is caught.

// File: rtl/port_pref_pkg.sv
package port_pref_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MATCH = 2'd1,
        PH_SEND  = 2'd2
    } phase_e;

    // Distance walking forward around a ring of n ports from base to idx.
    function automatic int unsigned ring_gap(int unsigned idx, int unsigned base, int unsigned n);
        return (idx >= base) ? (idx - base) : (idx + n - base);
    endfunction

endpackage

// File: rtl/pref_rank_core.sv
module pref_rank_core
    import port_pref_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            rr_sel,
    input  logic [IW-1:0]   ptr,
    input  logic [N-1:0]    elig,
    input  logic [N*CW-1:0] occ,
    input  logic [N*IW-1:0] lvl,
    output logic [N*IW-1:0] list_idx,
    output logic [N-1:0]    list_vld
);

    logic [IW-1:0] gap   [N];
    logic          ahead [N][N];   // ahead[i][j]: input j departs before input i
    logic [IW:0]   rank  [N];
    logic [IW:0]   total;

    for (genvar gi = 0; gi < N; gi++) begin : g_gap
        assign gap[gi] = IW'(ring_gap(gi, 32'(ptr), N));
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gi == gj) begin : g_self
                assign ahead[gi][gj] = 1'b0;
            end else begin : g_pair
                logic [CW-1:0] oi, oj;
                logic [IW-1:0] li, lj;
                logic          rr_win, sp_win;
                assign oi = occ[gi*CW +: CW];
                assign oj = occ[gj*CW +: CW];
                assign li = lvl[gi*IW +: IW];
                assign lj = lvl[gj*IW +: IW];
                assign rr_win = (oj < oi) || ((oj == oi) && (gap[gj] < gap[gi]));
                assign sp_win = (lj < li) || ((lj == li) && (gj < gi));
                assign ahead[gi][gj] = rr_sel ? rr_win : sp_win;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rank[i] = '0;
            for (int j = 0; j < N; j++) begin
                rank[i] = rank[i] + (IW+1)'(elig[j] && ahead[i][j]);
            end
        end
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + (IW+1)'(elig[i]);
        end
    end

    always_comb begin
        list_idx = '0;
        list_vld = '0;
        for (int k = 0; k < N; k++) begin
            list_vld[k] = ((IW+1)'(k) < total);
            for (int i = 0; i < N; i++) begin
                if (elig[i] && (rank[i] == (IW+1)'(k))) begin
                    list_idx[k*IW +: IW] = list_idx[k*IW +: IW] | IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/viq_pick.sv
module viq_pick
    import port_pref_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            rr_sel,
    input  logic [IW-1:0]   ptr,
    input  logic [N*CW-1:0] occ,
    input  logic [N*IW-1:0] lvl,
    output logic            any_cell,
    output logic [IW-1:0]   pick
);

    logic [N-1:0]  full;
    logic [N-1:0]  win;
    logic [IW-1:0] gap [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_lane
        assign full[gi] = |occ[gi*CW +: CW];
        assign gap[gi]  = IW'(ring_gap(gi, 32'(ptr), N));
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_win
        logic [N-1:0] beaten;
        for (genvar gj = 0; gj < N; gj++) begin : g_vs
            if (gi == gj) begin : g_self
                assign beaten[gj] = 1'b0;
            end else begin : g_pair
                logic [IW-1:0] li, lj;
                assign li = lvl[gi*IW +: IW];
                assign lj = lvl[gj*IW +: IW];
                assign beaten[gj] = full[gj] &&
                    (rr_sel ? (gap[gj] < gap[gi])
                            : ((lj < li) || ((lj == li) && (gj < gi))));
            end
        end
        assign win[gi] = full[gi] && !(|beaten);
    end

    assign any_cell = |full;

    always_comb begin
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) pick = pick | IW'(i);
        end
    end

endmodule

// File: rtl/port_pref_gen.sv
module port_pref_gen
    import port_pref_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pol_rr,
    input  logic            sched_go,
    input  logic            depart_go,
    input  logic [N-1:0]    voq_busy,
    input  logic [N*CW-1:0] viq_count,
    input  logic [N*IW-1:0] prio_lvl,
    output logic [N*IW-1:0] pref_idx,
    output logic [N-1:0]    pref_vld,
    output logic            list_fresh,
    output logic            dep_valid,
    output logic [IW-1:0]   dep_idx
);

    phase_e        phase_q, phase_d;
    logic [IW-1:0] ptr_q;
    logic [N*IW-1:0] list_idx_q, cur_idx;
    logic [N-1:0]  list_vld_q, cur_vld;
    logic          dep_hit_q;
    logic [IW-1:0] dep_idx_q;
    logic          cell_any;
    logic [IW-1:0] cell_pick, ptr_after;

    pref_rank_core #(.N(N), .CW(CW)) u_rank (
        .rr_sel   (pol_rr),
        .ptr      (ptr_q),
        .elig     (voq_busy),
        .occ      (viq_count),
        .lvl      (prio_lvl),
        .list_idx (cur_idx),
        .list_vld (cur_vld)
    );

    viq_pick #(.N(N), .CW(CW)) u_pick (
        .rr_sel   (pol_rr),
        .ptr      (ptr_q),
        .occ      (viq_count),
        .lvl      (prio_lvl),
        .any_cell (cell_any),
        .pick     (cell_pick)
    );

    assign ptr_after = (cell_pick == IW'(N-1)) ? '0 : cell_pick + 1'b1;

    // Phase selection: departure wins over a coincident scheduling strobe.
    always_comb begin
        unique case (phase_q)
            PH_IDLE, PH_MATCH, PH_SEND: begin
                if (depart_go)     phase_d = PH_SEND;
                else if (sched_go) phase_d = PH_MATCH;
                else               phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            list_idx_q <= '0;
            list_vld_q <= '0;
            dep_hit_q  <= 1'b0;
            dep_idx_q  <= '0;
        end else if (phase_d == PH_SEND) begin
            dep_hit_q <= cell_any;
            if (cell_any) begin
                dep_idx_q <= cell_pick;
                if (pol_rr) ptr_q <= ptr_after;
            end
        end else if (phase_d == PH_MATCH) begin
            list_idx_q <= cur_idx;
            list_vld_q <= cur_vld;
        end
    end

    always_comb begin
        list_fresh = 1'b0;
        dep_valid  = 1'b0;
        unique case (phase_q)
            PH_IDLE:  ;
            PH_MATCH: list_fresh = 1'b1;
            PH_SEND:  dep_valid  = dep_hit_q;
            default:  ;
        endcase
    end

    assign pref_idx = list_idx_q;
    assign pref_vld = list_vld_q;
    assign dep_idx  = dep_idx_q;

endmodule

// File: rtl/port_pref_gen_chk.sv
module port_pref_gen_chk #(
    parameter int N  = 4,
    parameter int CW = 4,
    localparam int IW = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            depart_go,
    input logic [N-1:0]    voq_busy,
    input logic [N*CW-1:0] viq_count,
    input logic [N*IW-1:0] pref_idx,
    input logic [N-1:0]    pref_vld,
    input logic            list_fresh,
    input logic            dep_valid
);

    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < N; k++) begin
            if (pref_vld[k]) seen[pref_idx[k*IW +: IW]] = 1'b1;
        end
    end

    assert_list_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pref_vld + N'(1)) & pref_vld) == '0);

    assert_list_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        list_fresh |-> ($countones(pref_vld) == $countones($past(voq_busy))));

    assert_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == $countones(pref_vld));

    assert_list_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !list_fresh |-> ($stable(pref_idx) && $stable(pref_vld)));

    assert_dep_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid |-> ($past(depart_go) && ($past(viq_count) != '0)));

    assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(list_fresh && dep_valid));

endmodule

bind port_pref_gen port_pref_gen_chk #(.N(N), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .depart_go  (depart_go),
    .voq_busy   (voq_busy),
    .viq_count  (viq_count),
    .pref_idx   (pref_idx),
    .pref_vld   (pref_vld),
    .list_fresh (list_fresh),
    .dep_valid  (dep_valid)
);

// File: tb/port_pref_gen_test.sv
`timescale 1ns/1ps
module port_pref_gen_test;
    localparam int N  = 4;
    localparam int CW = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pol_rr = 1'b1, sched_go = 1'b0, depart_go = 1'b0;
    logic [N-1:0]    voq_busy = '0;
    logic [N*CW-1:0] viq_count = '0;
    logic [N*IW-1:0] prio_lvl = '0;
    logic [N*IW-1:0] pref_idx;
    logic [N-1:0]    pref_vld;
    logic            list_fresh, dep_valid;
    logic [IW-1:0]   dep_idx;

    always #10 clk = ~clk;

    port_pref_gen #(.N(N), .CW(CW)) uut (.*);

    int checks = 0, errors = 0;
    int b_occ [N];
    int b_lvl [N];
    int m_ptr = 0;
    logic [N*IW-1:0] m_idx = '0;
    logic [N-1:0]    m_vld = '0;
    bit   m_fresh = 0, m_dep = 0;
    int   m_dep_idx = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int gap(int i, int p);
        return (i >= p) ? i - p : i + N - p;
    endfunction

    task automatic step(string tag, bit rr, bit sg, bit dg);
        bit taken [N];
        pol_rr = rr; sched_go = sg; depart_go = dg;
        for (int i = 0; i < N; i++) begin
            viq_count[i*CW +: CW] = CW'(b_occ[i]);
            prio_lvl[i*IW +: IW]  = IW'(b_lvl[i]);
        end
        m_fresh = 0; m_dep = 0;
        if (dg) begin
            int best = -1, bkey = 0;
            for (int i = 0; i < N; i++) begin
                int key = rr ? gap(i, m_ptr) : b_lvl[i] * N + i;
                if (b_occ[i] != 0 && (best < 0 || key < bkey)) begin best = i; bkey = key; end
            end
            if (best >= 0) begin
                m_dep = 1; m_dep_idx = best;
                if (rr) m_ptr = (best + 1) % N;
            end
        end else if (sg) begin
            m_fresh = 1; m_idx = '0; m_vld = '0;
            for (int i = 0; i < N; i++) taken[i] = 0;
            for (int k = 0; k < N; k++) begin
                int best = -1, bkey = 0;
                for (int i = 0; i < N; i++) begin
                    int key = rr ? b_occ[i] * N + gap(i, m_ptr) : b_lvl[i] * N + i;
                    if (voq_busy[i] && !taken[i] && (best < 0 || key < bkey)) begin best = i; bkey = key; end
                end
                if (best >= 0) begin
                    taken[best] = 1; m_vld[k] = 1'b1; m_idx[k*IW +: IW] = IW'(best);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(list_fresh == m_fresh, tag, "list_fresh R7", list_fresh, m_fresh);
        check(dep_valid == m_dep, tag, "dep_valid R8", dep_valid, m_dep);
        if (m_dep) check(dep_idx == IW'(m_dep_idx), tag, "dep_idx", dep_idx, m_dep_idx);
        check(pref_vld == m_vld, tag, "pref_vld R2", pref_vld, m_vld);
        check(pref_idx == m_idx, tag, "pref_idx R6", pref_idx, m_idx);
        sched_go = 0; depart_go = 0;
    endtask

    task automatic set_occ(int a, int b, int c, int d);
        b_occ[0] = a; b_occ[1] = b; b_occ[2] = c; b_occ[3] = d;
    endtask

    task automatic set_lvl(int a, int b, int c, int d);
        b_lvl[0] = a; b_lvl[1] = b; b_lvl[2] = c; b_lvl[3] = d;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_occ(0, 0, 0, 0); set_lvl(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check(pref_vld == '0 && !list_fresh && !dep_valid, "R1", "reset outputs",
              {pref_vld, list_fresh, dep_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: counts order the list; pointer 0
        voq_busy = 4'b1111; set_occ(2, 0, 1, 0);
        step("R3", 1, 1, 0);
        // R4: equal counts follow ring from pointer 0
        set_occ(1, 1, 1, 1);
        step("R4", 1, 1, 0);
        // R2: ineligible inputs with waiting cells are left out
        voq_busy = 4'b0101; set_occ(0, 0, 3, 5);
        step("R2", 1, 1, 0);
        voq_busy = 4'b0000;
        step("R2", 1, 1, 0);
        // R5: static levels, counts irrelevant
        voq_busy = 4'b1111; set_lvl(3, 0, 2, 1); set_occ(0, 9, 0, 9);
        step("R5", 0, 1, 0);
        set_lvl(1, 1, 0, 1);
        step("R5", 0, 1, 0);
        // R8 / R10: RR departure from pointer 0 moves pointer to 2
        set_occ(0, 2, 1, 0);
        step("R8", 1, 0, 1);
        set_occ(1, 1, 1, 1);
        step("R10", 1, 1, 0);
        // R10: wrap from input 3 to 0
        set_occ(1, 0, 0, 1);
        step("R8", 1, 0, 1);
        set_occ(2, 2, 2, 2);
        step("R10", 1, 1, 0);
        // R9: static departure, pointer untouched
        set_lvl(3, 0, 2, 1); set_occ(1, 0, 4, 0);
        step("R9", 0, 0, 1);
        set_occ(1, 1, 1, 1);
        step("R10", 1, 1, 0);
        // R8: all empty -> nothing departs, pointer untouched
        set_occ(0, 0, 0, 0);
        step("R8", 1, 0, 1);
        step("R10", 1, 1, 0);
        // R11: coincident strobes -> departure only, list held
        voq_busy = 4'b0011; set_occ(0, 0, 3, 0);
        step("R11", 1, 1, 1);
        // R7: no strobe -> list held
        voq_busy = 4'b1000;
        step("R7", 1, 0, 0);
        // Mixed sweep
        void'($urandom(7));
        for (int n = 0; n < 400; n++) begin
            bit rr = 1'($urandom_range(0, 1));
            int op = $urandom_range(0, 3);
            voq_busy = N'($urandom_range(0, 15));
            for (int i = 0; i < N; i++) begin
                b_occ[i] = $urandom_range(0, 3);
                b_lvl[i] = $urandom_range(0, 3);
            end
            step(rr ? "R3" : "R5", rr, op[0], op[1]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule